// File: doc/BRIEF.md
# DC Offset Estimator and Corrector

This block sits on the sample stream of one resolver channel, either sine or cosine, and removes the slow DC bias that the analog front end adds. Each signed ADC sample that arrives with its valid strobe updates a running leaky-integrator average of the input. Software can read that average as the offset estimate. When the correction enable is set, the estimate is subtracted from the sample before the sample is passed on. When the enable is clear, the sample passes through untouched. This lets a later bandpass stage, or a bypass path, take the output either way.

The estimate keeps running whether correction is on or off, so fault monitoring always sees the current offset. Correction can be switched on at any time, for example once sample-point selection has settled, and this does not disturb the estimate. A sticky fault flag is raised when the estimate grows beyond a programmed magnitude. It is also raised when the corrected output hits a rail, which is what happens when the excitation is missing.

Top module: `dc_offset_comp`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the estimate reads 0, the fault flag reads 0, and the output valid and output data read 0.
- R2: The estimate is kept with 12 fractional bits in an accumulator `acc`, starting from 0. On every sample with `smp_valid` high, `acc += ((x * 4096) - acc) >>> k`, using an arithmetic (floor) shift. The integer estimate `est_out` is `floor(acc / 4096)` and is visible one cycle after the sample.
- R3: The shift `k` is taken from `avg_shift`. Codes below 4 act as 4, and codes above 12 act as 12.
- R4: A cycle with `smp_valid` low leaves the estimate, the output data and the fault flag unchanged, and drives `out_valid` low on the next cycle.
- R5: With `corr_en` high, `out_data` equals the sample minus the integer estimate held before that sample's update. It appears one cycle after the sample, with `out_valid` high.
- R6: With `corr_en` low, `out_data` equals the input sample unchanged, one cycle later.
- R7: A corrected result above 32767 is output as 32767, and one below -32768 is output as -32768. It never wraps.
- R8: The fault flag is set when the magnitude of the updated estimate is strictly greater than `flt_thresh`.
- R9: The fault flag is set when a corrected sample saturates. A sample whose difference would be out of range but whose `corr_en` is low does not set it.
- R10: The fault flag stays set until `flt_clear` is high in a cycle with no new set condition. A set condition in the same cycle as a clear wins.
- R11: Toggling `corr_en` between samples does not change the sequence of estimates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed input sample |
| corr_en | input | 1 | Subtract estimate when high |
| avg_shift | input | SH_IN_W | Averaging shift code k |
| flt_thresh | input | DATA_W | Unsigned estimate magnitude limit |
| flt_clear | input | 1 | Clears the sticky fault |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Corrected or passed sample |
| est_out | output | DATA_W | Signed integer offset estimate |
| fault | output | 1 | Sticky fault flag |

## Verification
The main function is driven by a table of samples that mixes signs, full-scale values, both rails and every shift code, including codes outside the legal range. It also toggles the correction enable from sample to sample, so that a design which gates the estimate on the enable, or which clamps the shift incorrectly, drifts away from the reference sequence. Short hand-computed sequences fix the exact rounding of the first two updates, which separates a floor shift from a rounding one. A long run at -30000 followed by +30000 and the mirror case reach each rail with correction on and then off, which separates a correct saturation fault from one that ignores the enable. Threshold runs at 99 and 100 against an estimate of exactly 100 tell a strict comparison from an inclusive one.

// File: rtl/dco_pkg.sv
package dco_pkg;
   localparam int unsigned SHIFT_LO = 4;
   localparam int unsigned SHIFT_HI = 12;
   localparam int unsigned SHIFT_CODE_W = 4;
endpackage

// File: rtl/dco_shift_clamp.sv
module dco_shift_clamp #(
   parameter int unsigned IN_W  = 4,
   parameter int unsigned LO    = 4,
   parameter int unsigned HI    = 12,
   localparam int unsigned OUT_W = $clog2(HI + 1)
) (
   input  logic [IN_W-1:0]  code_in,
   output logic [OUT_W-1:0] shift_out
);
   localparam int unsigned CMP_W = (IN_W > OUT_W) ? IN_W : OUT_W;
   localparam logic [CMP_W-1:0] LO_C = CMP_W'(LO);
   localparam logic [CMP_W-1:0] HI_C = CMP_W'(HI);

   logic [CMP_W-1:0] code_w;

   generate
      if (CMP_W > IN_W) begin : g_pad
         assign code_w = {{(CMP_W-IN_W){1'b0}}, code_in};
      end else begin : g_same
         assign code_w = code_in;
      end
   endgenerate

   always_comb begin
      if (code_w < LO_C)
         shift_out = LO_C[OUT_W-1:0];
      else if (code_w > HI_C)
         shift_out = HI_C[OUT_W-1:0];
      else
         shift_out = code_w[OUT_W-1:0];
   end

   always_comb begin
      a_shift_range_r3 : assert (shift_out >= OUT_W'(LO) && shift_out <= OUT_W'(HI));
   end
endmodule

// File: rtl/dco_estimator.sv
module dco_estimator #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned SH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [SH_W-1:0]   shift,
   output logic [DATA_W-1:0] est_cur,
   output logic [DATA_W-1:0] est_next
);
   localparam int unsigned ACC_W = DATA_W + FRAC_W;
   localparam int unsigned DIF_W = ACC_W + 1;

   logic signed [ACC_W-1:0] acc_q, acc_d;
   logic signed [DIF_W-1:0] x_ext, diff, step;

   always_comb begin
      x_ext = {smp_data[DATA_W-1], smp_data, {FRAC_W{1'b0}}};
      diff  = x_ext - {acc_q[ACC_W-1], acc_q};
      step  = diff >>> shift;
      acc_d = smp_valid ? (acc_q + step[ACC_W-1:0]) : acc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else
         acc_q <= acc_d;
   end

   assign est_cur  = acc_q[ACC_W-1:FRAC_W];
   assign est_next = acc_d[ACC_W-1:FRAC_W];

   p_est_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(est_cur));
endmodule

// File: rtl/dco_corrector.sv
module dco_corrector #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              corr_en,
   input  logic [DATA_W-1:0] est_cur,
   output logic              sat_now,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam logic [DATA_W-1:0] POS_RAIL = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W:0]   diff;
   logic              hit_hi, hit_lo;
   logic [DATA_W-1:0] clamped, result;

   always_comb begin
      diff    = {smp_data[DATA_W-1], smp_data} - {est_cur[DATA_W-1], est_cur};
      hit_hi  = !diff[DATA_W] &&  diff[DATA_W-1];
      hit_lo  =  diff[DATA_W] && !diff[DATA_W-1];
      clamped = hit_hi ? POS_RAIL : (hit_lo ? NEG_RAIL : diff[DATA_W-1:0]);
      result  = corr_en ? clamped : smp_data;
      sat_now = smp_valid && corr_en && (hit_hi || hit_lo);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid)
            out_data <= result;
      end
   end

   p_bypass_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !corr_en) |=> (out_data == $past(smp_data)));
   p_strobe_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);
   p_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> (!out_valid && $stable(out_data)));
endmodule

// File: rtl/dco_fault_mon.sv
module dco_fault_mon #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] est_next,
   input  logic [DATA_W-1:0] thresh,
   input  logic              sat_now,
   input  logic              clr,
   output logic              fault
);
   logic [DATA_W:0] est_ext, mag;
   logic            over, set_ev;

   always_comb begin
      est_ext = {est_next[DATA_W-1], est_next};
      mag     = est_next[DATA_W-1] ? ((DATA_W+1)'(0) - est_ext) : est_ext;
      over    = smp_valid && (mag > {1'b0, thresh});
      set_ev  = over || sat_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         fault <= 1'b0;
      else if (set_ev)
         fault <= 1'b1;
      else if (clr)
         fault <= 1'b0;
   end

   p_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !clr) |=> fault);
   p_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !smp_valid) |=> !fault);
   p_sat_flag_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      sat_now |=> fault);
endmodule

// File: rtl/dc_offset_comp.sv
module dc_offset_comp #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned FRAC_W  = 12,
   parameter int unsigned SH_IN_W = dco_pkg::SHIFT_CODE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [DATA_W-1:0]  smp_data,
   input  logic               corr_en,
   input  logic [SH_IN_W-1:0] avg_shift,
   input  logic [DATA_W-1:0]  flt_thresh,
   input  logic               flt_clear,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   output logic [DATA_W-1:0]  est_out,
   output logic               fault
);
   localparam int unsigned SH_W = $clog2(dco_pkg::SHIFT_HI + 1);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
      if (FRAC_W < dco_pkg::SHIFT_HI) begin : g_bad_frac
         $error("FRAC_W must cover the largest shift");
      end
      if ((1 << SH_IN_W) <= dco_pkg::SHIFT_HI) begin : g_bad_code
         $error("SH_IN_W too narrow for the shift range");
      end
   endgenerate

   logic [SH_W-1:0]   shift_eff;
   logic [DATA_W-1:0] est_cur, est_next;
   logic              sat_now;

   dco_shift_clamp #(
      .IN_W (SH_IN_W),
      .LO   (dco_pkg::SHIFT_LO),
      .HI   (dco_pkg::SHIFT_HI)
   ) u_clamp (
      .code_in   (avg_shift),
      .shift_out (shift_eff)
   );

   dco_estimator #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W),
      .SH_W   (SH_W)
   ) u_est (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .shift     (shift_eff),
      .est_cur   (est_cur),
      .est_next  (est_next)
   );

   dco_corrector #(
      .DATA_W (DATA_W)
   ) u_corr (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .corr_en   (corr_en),
      .est_cur   (est_cur),
      .sat_now   (sat_now),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   dco_fault_mon #(
      .DATA_W (DATA_W)
   ) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .est_next  (est_next),
      .thresh    (flt_thresh),
      .sat_now   (sat_now),
      .clr       (flt_clear),
      .fault     (fault)
   );

   assign est_out = est_cur;

   p_est_free_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(est_out));
   p_reset_r1 : assert property (@(posedge clk)
      !rst_n |=> (!fault && !out_valid && est_out == '0));
endmodule

// File: tb/dc_offset_comp_test.sv
module dc_offset_comp_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        smp_valid;
   logic [15:0] smp_data;
   logic        corr_en;
   logic [3:0]  avg_shift;
   logic [15:0] flt_thresh;
   logic        flt_clear;
   logic        out_valid;
   logic [15:0] out_data;
   logic [15:0] est_out;
   logic        fault;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   dc_offset_comp uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .corr_en(corr_en), .avg_shift(avg_shift), .flt_thresh(flt_thresh),
      .flt_clear(flt_clear), .out_valid(out_valid), .out_data(out_data),
      .est_out(est_out), .fault(fault)
   );

   // reference state
   longint m_acc;
   int     m_out;
   bit     m_vld;
   bit     m_flt;

   localparam logic [20:0] VEC [0:15] = '{
      {16'd1000,  1'b0, 4'd4},  {16'd1200,  1'b0, 4'd4},
      {16'd900,   1'b1, 4'd5},  {16'hFC18,  1'b1, 4'd6},
      {16'd30000, 1'b1, 4'd3},  {16'h8AD0,  1'b1, 4'd13},
      {16'd0,     1'b0, 4'd8},  {16'd500,   1'b1, 4'd12},
      {16'h7FFF,  1'b1, 4'd4},  {16'h8000,  1'b1, 4'd4},
      {16'd2500,  1'b0, 4'd0},  {16'd2500,  1'b1, 4'd15},
      {16'hF830,  1'b1, 4'd7},  {16'd42,    1'b0, 4'd9},
      {16'd42,    1'b1, 4'd10}, {16'd7,     1'b1, 4'd11}
   };

   function automatic int sx(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_acc = 0; m_out = 0; m_vld = 0; m_flt = 0;
   endtask

   task automatic model_step(input bit v, input int x, input bit ce,
                             input int k, input bit clr, input int thr);
      int     kk;
      longint old_est, new_est, d, mag;
      bit     sat, setv;
      kk = (k < 4) ? 4 : ((k > 12) ? 12 : k);
      old_est = m_acc >>> 12;
      setv = 0;
      if (v) begin
         d = (longint'(x) <<< 12) - m_acc;
         m_acc = m_acc + (d >>> kk);
         new_est = m_acc >>> 12;
         d = longint'(x) - old_est;
         sat = (d > 32767) || (d < -32768);
         if (ce)
            m_out = (d > 32767) ? 32767 : ((d < -32768) ? -32768 : int'(d));
         else
            m_out = x;
         mag = (new_est < 0) ? -new_est : new_est;
         setv = (mag > longint'(thr)) || (ce && sat);
      end
      m_vld = v;
      if (setv) m_flt = 1;
      else if (clr) m_flt = 0;
   endtask

   // drive at negedge, clock in, compare at next negedge
   task automatic step(input bit v, input logic [15:0] x, input bit ce,
                       input logic [3:0] k, input bit clr, input string tag);
      smp_valid = v; smp_data = x; corr_en = ce; avg_shift = k; flt_clear = clr;
      @(posedge clk);
      model_step(v, sx(x), ce, int'(k), clr, int'(flt_thresh));
      @(negedge clk);
      smp_valid = 0; flt_clear = 0;
      chk({tag, " out_valid"}, int'(out_valid), int'(m_vld));
      chk({tag, " out_data"}, sx(out_data), m_out);
      chk({tag, " est_out"}, sx(est_out), int'(m_acc >>> 12));
      chk({tag, " fault"}, int'(fault), int'(m_flt));
   endtask

   task automatic do_reset();
      rst_n = 0; smp_valid = 0; smp_data = 0; corr_en = 0;
      avg_shift = 4; flt_clear = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      flt_thresh = 16'd20000;
      do_reset();
      // R1: reset state
      chk("R1 est", sx(est_out), 0);
      chk("R1 fault", int'(fault), 0);
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 out_data", sx(out_data), 0);

      // table walk: R2, R3, R5, R6, R7, R11 against reference sequence
      for (int i = 0; i < 16; i++)
         step(1'b1, VEC[i][20:5], VEC[i][4], VEC[i][3:0], 1'b0, "R2/R11 table");

      // R4: idle cycle holds everything
      step(1'b0, 16'd12345, 1'b1, 4'd4, 1'b0, "R4 idle");

      // R2 exact first updates, R5/R6 by hand
      flt_thresh = 16'h7FFF;
      do_reset();
      step(1'b1, 16'd1600, 1'b0, 4'd4, 1'b0, "R2 first");
      chk("R2 est 100", sx(est_out), 100);
      chk("R6 passthru", sx(out_data), 1600);
      step(1'b1, 16'd1600, 1'b1, 4'd4, 1'b0, "R5 second");
      chk("R5 corrected", sx(out_data), 1500);
      chk("R2 est 193", sx(est_out), 193);

      // R3 clamp low and high
      do_reset();
      step(1'b1, 16'd4096, 1'b0, 4'd0, 1'b0, "R3 low");
      chk("R3 k0 acts as 4", sx(est_out), 256);
      do_reset();
      step(1'b1, 16'd4096, 1'b0, 4'd15, 1'b0, "R3 high");
      chk("R3 k15 acts as 12", sx(est_out), 1);

      // R8 strict threshold
      flt_thresh = 16'd99;
      do_reset();
      step(1'b1, 16'd1600, 1'b0, 4'd4, 1'b0, "R8 over");
      chk("R8 fault above 99", int'(fault), 1);
      flt_thresh = 16'd100;
      do_reset();
      step(1'b1, 16'd1600, 1'b0, 4'd4, 1'b0, "R8 equal");
      chk("R8 no fault at 100", int'(fault), 0);

      // R7/R9/R10 positive rail
      flt_thresh = 16'h7FFF;
      do_reset();
      for (int i = 0; i < 300; i++)
         step(1'b1, 16'h8AD0, 1'b0, 4'd4, 1'b0, "R9 prefill");
      step(1'b1, 16'd30000, 1'b0, 4'd4, 1'b0, "R9 bypass no sat");
      chk("R9 no fault when corr off", int'(fault), 0);
      chk("R6 raw 30000", sx(out_data), 30000);
      step(1'b1, 16'd30000, 1'b1, 4'd4, 1'b0, "R7 pos rail");
      chk("R7 clamp high", sx(out_data), 32767);
      chk("R9 fault on sat", int'(fault), 1);
      step(1'b0, 16'd0, 1'b0, 4'd4, 1'b0, "R10 hold");
      chk("R10 sticky", int'(fault), 1);
      step(1'b0, 16'd0, 1'b0, 4'd4, 1'b1, "R10 clear");
      chk("R10 cleared", int'(fault), 0);

      // R7 negative rail, R10 set wins over clear
      do_reset();
      for (int i = 0; i < 300; i++)
         step(1'b1, 16'd30000, 1'b0, 4'd4, 1'b0, "R7 prefill");
      step(1'b1, 16'h8AD0, 1'b1, 4'd4, 1'b1, "R10 set vs clear");
      chk("R7 clamp low", sx(out_data), -32768);
      chk("R10 set wins", int'(fault), 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule